// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder

This block turns one 16-bit instruction word into the full set of control signals that a single-cycle datapath needs in the same cycle. It is purely combinational. The instruction holds a 7-bit opcode and three 3-bit register fields: a destination, a first source and a second source.

The decoder drives several groups of outputs:
- the register-file addresses and the register write enable;
- the choice between a register operand and an immediate operand for the second ALU input;
- the function-unit group and the select within that group;
- the memory write strobe and the write-back source;
- the branch and jump controls.

It also forms two constants from the instruction. The immediate is the second-source field zero-filled to the data width. The branch offset is the destination and second-source fields joined and sign-extended.

The top opcode bit picks between the register form and the immediate form of every ALU operation. Other opcode prefixes mark stores, loads, conditional branches and jumps, and the low opcode bits in those ranges are don't-cares. Opcodes with no defined meaning leave every piece of architectural state untouched.

Top module: `scd_decoder`

## Requirements
- R1: Instruction fields: opcode is bits 15:9, destination is 8:6, first source is 5:3, second source is 2:0. These appear unchanged on `rd_addr_o`, `ra_addr_o` and `rb_addr_o` for every opcode.
- R2: Opcodes x000sss are the arithmetic group. They give `fu_grp_o`=0, `fu_sel_o`=sss and `rf_we_o`=1.
- R3: Opcodes x001ssx are the logic group. They give `fu_grp_o`=1, `fu_sel_o`={0,ss} and `rf_we_o`=1. Opcode bit 0 has no effect.
- R4: Opcodes x01ssxx with ss of 00, 01 or 10 are the shift/transfer group (pass B, shift right, shift left). They give `fu_grp_o`=2, `fu_sel_o`={0,ss} and `rf_we_o`=1.
- R5: Opcodes x0111xx are undefined. They give `illegal_o`=1, `rf_we_o`=0, `mem_we_o`=0, `br_en_o`=0, `jmp_en_o`=0, `fu_grp_o`=3 and `fu_sel_o`=0.
- R6: `b_imm_o` is 1 exactly for defined ALU opcodes with bit 6 set (10xxxxx). It is 0 for the register forms and for every other class.
- R7: `imm_o` is the second-source field zero-filled to DATA_W bits, for every instruction.
- R8: Opcodes 010xxxx are stores. They give `mem_we_o`=1, `rf_we_o`=0, `wb_mem_o`=0 and `fu_grp_o`=3.
- R9: Opcodes 011xxxx are loads. They give `rf_we_o`=1, `wb_mem_o`=1, `mem_we_o`=0 and `fu_grp_o`=3.
- R10: Opcodes 110xicc are conditional branches. They give `br_en_o`=1, `br_cond_o`=cc (0 carry, 1 negative, 2 overflow, 3 zero) and `br_inv_o`=i, with no register or memory write.
- R11: Opcodes 111xxxx are jumps. They give `jmp_en_o`=1 and `br_en_o`=0, with no register or memory write.
- R12: `off_o` is the 6-bit value {destination, second source} sign-extended to DATA_W bits.
- R13: At most one of `mem_we_o`, `wb_mem_o`, `br_en_o` and `jmp_en_o` is 1 for any instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| rd_addr_o | output | 3 | Destination register address |
| ra_addr_o | output | 3 | First source register address |
| rb_addr_o | output | 3 | Second source register address |
| rf_we_o | output | 1 | Register file write enable |
| b_imm_o | output | 1 | Second ALU operand taken from immediate |
| fu_grp_o | output | 2 | Function-unit group: 0 arith, 1 logic, 2 shift, 3 none |
| fu_sel_o | output | 3 | Operation select within the group |
| mem_we_o | output | 1 | Data memory write strobe |
| wb_mem_o | output | 1 | Write-back value taken from memory |
| br_en_o | output | 1 | Conditional branch |
| br_cond_o | output | 2 | Branch flag select |
| br_inv_o | output | 1 | Branch on flag clear |
| jmp_en_o | output | 1 | Unconditional jump |
| illegal_o | output | 1 | Opcode undefined |
| imm_o | output | DATA_W | Zero-filled immediate |
| off_o | output | DATA_W | Sign-extended branch offset |

## Verification
The bench sweeps all 128 opcodes. This catches a decoder that puts a prefix boundary in the wrong place, for example one that treats the undefined shift slot as a shift left and so corrupts a register. It also catches a decoder that reads bit 6 as part of the store/load prefix, which would write memory for an immediate ALU opcode. Bit 0 of a logic opcode is flipped to expose a decoder that folds it into the select, which would turn OR into something else. The branch offset is checked with the sign bit set and clear, because a zero-extension would send backward branches forward.

// File: rtl/scd_pkg.sv
package scd_pkg;
   localparam int OPC_W  = 7;
   localparam int FSEL_W = 3;

   typedef enum logic [1:0] {
      FU_ARITH = 2'd0,
      FU_LOGIC = 2'd1,
      FU_SHIFT = 2'd2,
      FU_NONE  = 2'd3
   } fu_grp_e;

   typedef enum logic [2:0] {
      K_ALU    = 3'd0,
      K_STORE  = 3'd1,
      K_LOAD   = 3'd2,
      K_BRANCH = 3'd3,
      K_JUMP   = 3'd4,
      K_BAD    = 3'd5
   } kind_e;
endpackage

// File: rtl/scd_opclass.sv
module scd_opclass
   import scd_pkg::*;
#(
   parameter int OP_W = OPC_W
) (
   input  logic [OP_W-1:0]   op_i,
   output kind_e             kind_o,
   output fu_grp_e           grp_o,
   output logic [FSEL_W-1:0] fsel_o,
   output logic              imm_form_o,
   output logic [1:0]        cond_o,
   output logic              cond_inv_o
);
   generate
      if (OP_W != 7) begin : g_bad_opw
         $error("scd_opclass: opcode map assumes 7 bits");
      end
   endgenerate

   always_comb begin
      kind_o     = K_BAD;
      grp_o      = FU_NONE;
      fsel_o     = '0;
      imm_form_o = 1'b0;
      cond_o     = 2'b00;
      cond_inv_o = 1'b0;
      if (!op_i[5]) begin
         // ALU region, bit 6 picks register or immediate form
         if (!op_i[4]) begin
            kind_o     = K_ALU;
            imm_form_o = op_i[6];
            if (!op_i[3]) begin
               grp_o  = FU_ARITH;
               fsel_o = FSEL_W'(op_i[2:0]);
            end else begin
               grp_o  = FU_LOGIC;
               fsel_o = FSEL_W'(op_i[2:1]);
            end
         end else if (op_i[3:2] != 2'b11) begin
            kind_o     = K_ALU;
            imm_form_o = op_i[6];
            grp_o      = FU_SHIFT;
            fsel_o     = FSEL_W'(op_i[3:2]);
         end
      end else begin
         unique case ({op_i[6], op_i[4]})
            2'b00: kind_o = K_STORE;
            2'b01: kind_o = K_LOAD;
            2'b10: begin
               kind_o     = K_BRANCH;
               cond_o     = op_i[1:0];
               cond_inv_o = op_i[2];
            end
            default: kind_o = K_JUMP;
         endcase
      end
   end
endmodule

// File: rtl/scd_ctrl_map.sv
module scd_ctrl_map
   import scd_pkg::*;
(
   input  kind_e kind_i,
   input  logic  imm_form_i,
   output logic  rf_we_o,
   output logic  mem_we_o,
   output logic  wb_mem_o,
   output logic  b_imm_o,
   output logic  br_en_o,
   output logic  jmp_en_o,
   output logic  illegal_o
);
   always_comb begin
      rf_we_o   = 1'b0;
      mem_we_o  = 1'b0;
      wb_mem_o  = 1'b0;
      b_imm_o   = 1'b0;
      br_en_o   = 1'b0;
      jmp_en_o  = 1'b0;
      illegal_o = 1'b0;
      unique case (kind_i)
         K_ALU: begin
            rf_we_o = 1'b1;
            b_imm_o = imm_form_i;
         end
         K_STORE:  mem_we_o = 1'b1;
         K_LOAD: begin
            rf_we_o  = 1'b1;
            wb_mem_o = 1'b1;
         end
         K_BRANCH: br_en_o = 1'b1;
         K_JUMP:   jmp_en_o = 1'b1;
         default:  illegal_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/scd_const_gen.sv
module scd_const_gen #(
   parameter int REG_AW = 3,
   parameter int DATA_W = 16
) (
   input  logic [REG_AW-1:0] dr_i,
   input  logic [REG_AW-1:0] sb_i,
   output logic [DATA_W-1:0] imm_o,
   output logic [DATA_W-1:0] off_o
);
   localparam int OFF_W = 2 * REG_AW;

   logic [OFF_W-1:0] raw_off;
   assign raw_off = {dr_i, sb_i};

   generate
      if (DATA_W < OFF_W) begin : g_bad_w
         $error("scd_const_gen: DATA_W must hold the joined offset");
      end
      if (DATA_W == REG_AW) begin : g_imm_eq
         assign imm_o = sb_i;
      end else begin : g_imm_zf
         assign imm_o = {{(DATA_W-REG_AW){1'b0}}, sb_i};
      end
      if (DATA_W == OFF_W) begin : g_off_eq
         assign off_o = raw_off;
      end else begin : g_off_se
         assign off_o = {{(DATA_W-OFF_W){raw_off[OFF_W-1]}}, raw_off};
      end
   endgenerate
endmodule

// File: rtl/scd_decoder.sv
module scd_decoder
   import scd_pkg::*;
#(
   parameter int REG_AW = 3,
   parameter int DATA_W = 16
) (
   input  logic [OPC_W+3*REG_AW-1:0] instr_i,
   output logic [REG_AW-1:0]         rd_addr_o,
   output logic [REG_AW-1:0]         ra_addr_o,
   output logic [REG_AW-1:0]         rb_addr_o,
   output logic                      rf_we_o,
   output logic                      b_imm_o,
   output logic [1:0]                fu_grp_o,
   output logic [FSEL_W-1:0]         fu_sel_o,
   output logic                      mem_we_o,
   output logic                      wb_mem_o,
   output logic                      br_en_o,
   output logic [1:0]                br_cond_o,
   output logic                      br_inv_o,
   output logic                      jmp_en_o,
   output logic                      illegal_o,
   output logic [DATA_W-1:0]         imm_o,
   output logic [DATA_W-1:0]         off_o
);
   localparam int INSTR_W = OPC_W + 3 * REG_AW;
   localparam int SB_LSB  = 0;
   localparam int SA_LSB  = REG_AW;
   localparam int DR_LSB  = 2 * REG_AW;
   localparam int OP_LSB  = 3 * REG_AW;

   generate
      if (REG_AW < 1) begin : g_bad_aw
         $error("scd_decoder: REG_AW must be positive");
      end
   endgenerate

   logic [OPC_W-1:0]  opc;
   logic [REG_AW-1:0] f_dr, f_sa, f_sb;
   kind_e             kind;
   fu_grp_e           grp;
   logic              imm_form;

   assign opc  = instr_i[INSTR_W-1:OP_LSB];
   assign f_dr = instr_i[DR_LSB +: REG_AW];
   assign f_sa = instr_i[SA_LSB +: REG_AW];
   assign f_sb = instr_i[SB_LSB +: REG_AW];

   assign rd_addr_o = f_dr;
   assign ra_addr_o = f_sa;
   assign rb_addr_o = f_sb;

   scd_opclass #(.OP_W(OPC_W)) u_cls (
      .op_i       (opc),
      .kind_o     (kind),
      .grp_o      (grp),
      .fsel_o     (fu_sel_o),
      .imm_form_o (imm_form),
      .cond_o     (br_cond_o),
      .cond_inv_o (br_inv_o)
   );

   assign fu_grp_o = grp;

   scd_ctrl_map u_map (
      .kind_i     (kind),
      .imm_form_i (imm_form),
      .rf_we_o    (rf_we_o),
      .mem_we_o   (mem_we_o),
      .wb_mem_o   (wb_mem_o),
      .b_imm_o    (b_imm_o),
      .br_en_o    (br_en_o),
      .jmp_en_o   (jmp_en_o),
      .illegal_o  (illegal_o)
   );

   scd_const_gen #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_cst (
      .dr_i  (f_dr),
      .sb_i  (f_sb),
      .imm_o (imm_o),
      .off_o (off_o)
   );

   always_comb begin
      a_r5_illegal_quiet: assert (!illegal_o ||
         (!rf_we_o && !mem_we_o && !br_en_o && !jmp_en_o && fu_grp_o == 2'd3))
         else $error("R5: undefined opcode altered state");
      a_r6_imm_needs_fu: assert (!b_imm_o || fu_grp_o != 2'd3)
         else $error("R6: immediate select outside ALU class");
      a_r8_store_no_rf: assert (!mem_we_o || !rf_we_o)
         else $error("R8: store also writes register file");
      a_r10_branch_no_wr: assert (!(br_en_o || jmp_en_o) || (!rf_we_o && !mem_we_o))
         else $error("R10: control transfer writes state");
      a_r13_excl: assert ($countones({mem_we_o, wb_mem_o, br_en_o, jmp_en_o}) <= 1)
         else $error("R13: more than one class strobe");
      a_r9_load_rf: assert (!wb_mem_o || rf_we_o)
         else $error("R9: load without register write");
   end
endmodule

// File: tb/sim_scd_decoder.sv
module sim_scd_decoder;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [15:0]   instr;
   logic [2:0]    rd_a, ra_a, rb_a, fsel;
   logic          rf_we, b_imm, mem_we, wb_mem, br_en, br_inv, jmp_en, illegal;
   logic [1:0]    grp, cond;
   logic [DW-1:0] imm, off;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   scd_decoder #(.REG_AW(3), .DATA_W(DW)) u0 (
      .instr_i(instr), .rd_addr_o(rd_a), .ra_addr_o(ra_a), .rb_addr_o(rb_a),
      .rf_we_o(rf_we), .b_imm_o(b_imm), .fu_grp_o(grp), .fu_sel_o(fsel),
      .mem_we_o(mem_we), .wb_mem_o(wb_mem), .br_en_o(br_en), .br_cond_o(cond),
      .br_inv_o(br_inv), .jmp_en_o(jmp_en), .illegal_o(illegal),
      .imm_o(imm), .off_o(off)
   );

   // packed order: rf_we mem_we wb_mem b_imm br_en jmp_en illegal grp[1:0] sel[2:0]
   localparam int NV = 12;
   localparam logic [6:0] V_OP [NV] = '{
      7'b0000010, 7'b1000101, 7'b0001011, 7'b1001110, 7'b0010100, 7'b1011000,
      7'b0011101, 7'b1011111, 7'b0100110, 7'b0111001, 7'b1101110, 7'b1110011};
   localparam logic [11:0] V_EXP [NV] = '{
      12'b100000000010, 12'b100100000101, 12'b100000001001, 12'b100100001011,
      12'b100000010001, 12'b100100010010, 12'b000000111000, 12'b000000111000,
      12'b010000011000, 12'b101000011000, 12'b000010011000, 12'b000001011000};

   function automatic logic [11:0] got_word();
      return {rf_we, mem_we, wb_mem, b_imm, br_en, jmp_en, illegal, grp, fsel};
   endfunction

   // expected control word derived from the requirement text
   function automatic logic [11:0] model(input logic [6:0] o);
      logic [11:0] w;
      w = 12'b000000011000;
      if (o[5:4] == 2'b00 && !o[3])                      w = {1'b1, 2'b00, o[6], 3'b000, 2'd0, o[2:0]};     // R2
      else if (o[5:4] == 2'b00)                          w = {1'b1, 2'b00, o[6], 3'b000, 2'd1, 1'b0, o[2:1]}; // R3
      else if (o[5:4] == 2'b01 && o[3:2] != 2'b11)       w = {1'b1, 2'b00, o[6], 3'b000, 2'd2, 1'b0, o[3:2]}; // R4
      else if (o[5:4] == 2'b01)                          w = 12'b000000111000;                               // R5
      else if (o[6:4] == 3'b010)                         w = 12'b010000011000;                               // R8
      else if (o[6:4] == 3'b011)                         w = 12'b101000011000;                               // R9
      else if (o[6:4] == 3'b110)                         w = 12'b000010011000;                               // R10
      else                                               w = 12'b000001011000;                               // R11
      return w;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [15:0] v);
      @(posedge clk);
      instr = v;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 50000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      instr = 16'h0000;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state: cleared instruction bus decodes register transfer (R2)
      chk("R2 reset word", 32'(got_word()), 32'(12'b100000000000));
      chk("R7 reset imm", 32'(imm), 32'd0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         drive({V_OP[i], 9'b101_011_110});
         chk($sformatf("R2-table[%0d] ctrl R%0d", i, 0), 32'(got_word()), 32'(V_EXP[i]));
      end

      // exhaustive opcode sweep
      for (int o = 0; o < 128; o++) begin
         drive({7'(o), 9'b011_101_001});
         chk($sformatf("R13 sweep op=%0h ctrl", o), 32'(got_word()), 32'(model(7'(o))));
         if (o[6:4] == 3'b110) begin
            chk("R10 cond", 32'(cond), 32'(o[1:0]));
            chk("R10 inv", 32'(br_inv), 32'(o[2]));
         end
         if (o[6:5] == 2'b10 && o[4:2] != 3'b111)
            chk("R6 imm form", 32'(b_imm), 32'd1);
      end

      // R1 field pass-through
      drive({7'b1110000, 3'b110, 3'b001, 3'b101});
      chk("R1 rd", 32'(rd_a), 32'd6);
      chk("R1 ra", 32'(ra_a), 32'd1);
      chk("R1 rb", 32'(rb_a), 32'd5);
      chk("R11 jump", 32'(jmp_en), 32'd1);

      // R3 bit 0 ignored for logic
      drive({7'b0001010, 9'd0});
      chk("R3 b0=0 sel", 32'(fsel), 32'd1);
      drive({7'b0001011, 9'd0});
      chk("R3 b0=1 sel", 32'(fsel), 32'd1);

      // R7 zero fill, R12 sign extension
      drive({7'b1000010, 3'b100, 3'b000, 3'b111});
      chk("R7 imm", 32'(imm), 32'h0007);
      chk("R12 off negative", 32'(off), 32'hFFE7);
      drive({7'b1100000, 3'b011, 3'b000, 3'b010});
      chk("R12 off positive", 32'(off), 32'h001A);
      chk("R6 branch not imm", 32'(b_imm), 32'd0);

      // R4 shift right register form, R5 undefined immediate form
      drive({7'b0010111, 9'd0});
      chk("R4 shift grp", 32'(grp), 32'd2);
      drive({7'b1011100, 9'd0});
      chk("R5 illegal", 32'(illegal), 32'd1);
      chk("R5 no rf write", 32'(rf_we), 32'd0);

      // R8 / R9 with bit 6 clear only
      drive({7'b0101111, 9'd0});
      chk("R8 store we", 32'(mem_we), 32'd1);
      drive({7'b0110000, 9'd0});
      chk("R9 load wb", 32'(wb_mem), 32'd1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule